// File: doc/BRIEF.md
# Lazy Coprocessor-Context Fault Gate

This block holds the three control-register flags that steer lazy saving of floating-point and SIMD state across task switches: task-switched, emulate, and monitor-coprocessor. Hardware sets the task-switched flag whenever a task switch happens. A dedicated clearing instruction clears it, and a software write to the control register can also load it. For every decoded instruction, the block tells the pipeline whether a device-not-available fault must be taken before that instruction executes.

The decode stage supplies a class code with a valid strobe, and the block answers in the same cycle. The operating system uses the fault to save and restore coprocessor context only when the new task actually touches that state. Instructions that never need the coprocessor context are never gated.

Top module: `lazy_ctx_gate`

## Requirements
- R1: After reset, the task-switched, emulate and monitor flags all read 0.
- R2: A task-switch event sets the task-switched flag at the next clock edge. It wins over a clear strobe or a control-register write in the same cycle.
- R3: A clear strobe with no task-switch event clears the task-switched flag at the next edge. In the same cycle it also wins over the value a control-register write gives that flag.
- R4: A control-register write loads task-switched from data bit 3, emulate from bit 2 and monitor from bit 1 at the next edge. All other data bits are ignored.
- R5: The fault output is combinational. With valid high, class 1 (floating-point) or class 2 (SIMD), task-switched 1 and emulate 0, the fault is raised in the same cycle.
- R6: While emulate is 1, class 1 and class 2 instructions never fault, whatever the task-switched flag holds.
- R7: A class 3 (wait) instruction faults exactly when task-switched is 1 and monitor is 1. With monitor at 0 it does not fault.
- R8: Class 4 (exempt: pause, prefetch hints, fences, non-temporal store, cache-line flush, CRC, population count), class 0 (other) and the unused codes 5 to 7 never fault.
- R9: With valid low, the fault output is 0.
- R10: With no task-switch event, no clear strobe and no write, all three flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| task_sw_i | input | 1 | Task-switch event strobe |
| clr_ts_i | input | 1 | Clear-task-switched instruction strobe |
| cr_wr_i | input | 1 | Control-register write enable |
| cr_wdata_i | input | 32 | Control-register write data |
| insn_vld_i | input | 1 | Decoded instruction valid |
| insn_cls_i | input | 3 | Instruction class code |
| fault_o | output | 1 | Device-not-available fault request |
| ts_o | output | 1 | Task-switched flag |
| em_o | output | 1 | Emulate flag |
| mp_o | output | 1 | Monitor-coprocessor flag |

## Verification
The fault result is due in the same cycle as the instruction class that causes it. A flag update is due one clock edge after the event that causes it. The driver applies each stimulus on the falling edge and queues the fault it expects, computed from the model flags as they stood before that stimulus, together with those flags. The monitor checks the item shortly before the next rising edge, so each flag update is checked against the item of the following stimulus, exactly one edge later.

// File: rtl/lazy_ctx_gate.sv
module lazy_ctx_gate #(
  parameter int DW     = 32,
  parameter int TS_BIT = 3,
  parameter int EM_BIT = 2,
  parameter int MP_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          task_sw_i,
  input  logic          clr_ts_i,
  input  logic          cr_wr_i,
  input  logic [DW-1:0] cr_wdata_i,
  input  logic          insn_vld_i,
  input  logic [2:0]    insn_cls_i,
  output logic          fault_o,
  output logic          ts_o,
  output logic          em_o,
  output logic          mp_o
);
  localparam logic [2:0] CLS_FP   = 3'd1;
  localparam logic [2:0] CLS_SIMD = 3'd2;
  localparam logic [2:0] CLS_WAIT = 3'd3;

  logic ts_q, em_q, mp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q <= 1'b0;
      em_q <= 1'b0;
      mp_q <= 1'b0;
    end else begin
      if (cr_wr_i) begin
        em_q <= cr_wdata_i[EM_BIT];
        mp_q <= cr_wdata_i[MP_BIT];
      end
      if (task_sw_i)     ts_q <= 1'b1;
      else if (clr_ts_i) ts_q <= 1'b0;
      else if (cr_wr_i)  ts_q <= cr_wdata_i[TS_BIT];
    end
  end

  wire is_cop  = (insn_cls_i == CLS_FP) || (insn_cls_i == CLS_SIMD);
  wire is_wait = (insn_cls_i == CLS_WAIT);

  assign fault_o = insn_vld_i && ts_q &&
                   ((is_cop && !em_q) || (is_wait && mp_q));
  assign ts_o = ts_q;
  assign em_o = em_q;
  assign mp_o = mp_q;
endmodule

// File: rtl/lazy_ctx_gate_chk.sv
module lazy_ctx_gate_chk #(
  parameter int DW     = 32,
  parameter int TS_BIT = 3,
  parameter int EM_BIT = 2,
  parameter int MP_BIT = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          task_sw_i,
  input logic          clr_ts_i,
  input logic          cr_wr_i,
  input logic [DW-1:0] cr_wdata_i,
  input logic          insn_vld_i,
  input logic [2:0]    insn_cls_i,
  input logic          fault_o,
  input logic          ts_o,
  input logic          em_o,
  input logic          mp_o
);
  wire cop = (insn_cls_i == 3'd1) || (insn_cls_i == 3'd2);

  assert_ts_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    task_sw_i |=> ts_o);
  assert_ts_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ts_i && !task_sw_i) |=> !ts_o);
  assert_wr_ts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_wr_i && !task_sw_i && !clr_ts_i) |=> (ts_o == $past(cr_wdata_i[TS_BIT])));
  assert_wr_em_mp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cr_wr_i |=> (em_o == $past(cr_wdata_i[EM_BIT]) && mp_o == $past(cr_wdata_i[MP_BIT])));
  assert_cop_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld_i && cop && ts_o && !em_o) |-> fault_o);
  assert_em_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld_i && cop && em_o) |-> !fault_o);
  assert_wait_rule_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld_i && insn_cls_i == 3'd3) |-> (fault_o == (ts_o && mp_o)));
  assert_exempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_cls_i == 3'd0 || insn_cls_i >= 3'd4) |-> !fault_o);
  assert_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_vld_i |-> !fault_o);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!task_sw_i && !clr_ts_i && !cr_wr_i) |=> $stable({ts_o, em_o, mp_o}));
endmodule

bind lazy_ctx_gate lazy_ctx_gate_chk #(.DW(DW), .TS_BIT(TS_BIT), .EM_BIT(EM_BIT), .MP_BIT(MP_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .task_sw_i(task_sw_i), .clr_ts_i(clr_ts_i),
  .cr_wr_i(cr_wr_i), .cr_wdata_i(cr_wdata_i), .insn_vld_i(insn_vld_i),
  .insn_cls_i(insn_cls_i), .fault_o(fault_o), .ts_o(ts_o), .em_o(em_o), .mp_o(mp_o));

// File: tb/tb_lazy_ctx_gate.sv
`timescale 1ns/1ps
module tb_lazy_ctx_gate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic task_sw = 1'b0, clr_ts = 1'b0, cr_wr = 1'b0, vld = 1'b0;
  logic [31:0] wdata = '0;
  logic [2:0]  cls = '0;
  logic fault, ts, em, mp;

  always #2.5 clk = ~clk;

  lazy_ctx_gate dut (
    .clk(clk), .rst_n(rst_n), .task_sw_i(task_sw), .clr_ts_i(clr_ts),
    .cr_wr_i(cr_wr), .cr_wdata_i(wdata), .insn_vld_i(vld), .insn_cls_i(cls),
    .fault_o(fault), .ts_o(ts), .em_o(em), .mp_o(mp));

  typedef struct {
    logic       f;
    logic [2:0] flags;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  logic m_ts = 1'b0, m_em = 1'b0, m_mp = 1'b0;
  bit done = 0;

  task automatic step(input logic t_sw, input logic t_clr, input logic t_wr,
                      input logic [31:0] t_d, input logic t_vld,
                      input logic [2:0] t_cls, input string tag);
    item_t it;
    @(negedge clk);
    task_sw = t_sw; clr_ts = t_clr; cr_wr = t_wr; wdata = t_d;
    vld = t_vld; cls = t_cls;
    it.f = t_vld && m_ts && ((((t_cls == 3'd1) || (t_cls == 3'd2)) && !m_em) ||
                             ((t_cls == 3'd3) && m_mp));
    it.flags = {m_ts, m_em, m_mp};
    it.tag = tag;
    q.push_back(it);
    if (t_wr) begin m_em = t_d[2]; m_mp = t_d[1]; end
    if (t_sw) m_ts = 1'b1;
    else if (t_clr) m_ts = 1'b0;
    else if (t_wr) m_ts = t_d[3];
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() != 0) begin
        it = q.pop_front();
        checks++;
        if (fault !== it.f) begin
          fails++;
          $display("FAIL %s fault: actual %b expected %b", it.tag, fault, it.f);
        end
        checks++;
        if ({ts, em, mp} !== it.flags) begin
          fails++;
          $display("FAIL %s flags ts/em/mp: actual %b expected %b", it.tag, {ts, em, mp}, it.flags);
        end
      end
    end
  end

  initial begin : watchdog
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 32'h0, 1, 3'd1, "R1 reset flags, fp no fault");
    step(1, 0, 0, 32'h0, 0, 3'd0, "R2 task switch");
    step(0, 0, 0, 32'h0, 1, 3'd1, "R5 fp faults");
    step(0, 0, 0, 32'h0, 1, 3'd2, "R5 simd faults");
    step(0, 0, 0, 32'h0, 1, 3'd3, "R7 wait mp=0");
    step(0, 0, 0, 32'h0, 1, 3'd4, "R8 exempt");
    step(0, 0, 0, 32'h0, 1, 3'd0, "R8 other");
    step(0, 0, 0, 32'h0, 1, 3'd6, "R8 unused code");
    step(0, 0, 0, 32'h0, 0, 3'd1, "R9 valid low");
    step(0, 0, 1, 32'hFFF0_00FA, 0, 3'd0, "R4 write ts/mp, junk bits");
    step(0, 0, 0, 32'h0, 1, 3'd3, "R7 wait mp=1");
    step(0, 0, 0, 32'h0, 1, 3'd1, "R10 hold, fp faults");
    step(0, 0, 1, 32'h0000_000E, 0, 3'd0, "R4 write em");
    step(0, 0, 0, 32'h0, 1, 3'd1, "R6 fp with em");
    step(0, 0, 0, 32'h0, 1, 3'd2, "R6 simd with em");
    step(0, 0, 0, 32'h0, 1, 3'd3, "R7 wait with em");
    step(0, 1, 0, 32'h0, 0, 3'd0, "R3 clear");
    step(0, 0, 0, 32'h0, 1, 3'd3, "R3 wait after clear");
    step(1, 1, 0, 32'h0, 1, 3'd2, "R2 switch beats clear");
    step(1, 0, 1, 32'h0, 1, 3'd3, "R2 switch beats write");
    step(0, 1, 1, 32'h0000_0008, 1, 3'd1, "R3 clear beats write");
    step(0, 0, 0, 32'h0, 1, 3'd1, "R10 final hold");
    step(0, 0, 0, 32'h0, 0, 3'd0, "R10 idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule